// File: doc/BRIEF.md
# USB Hub Port Control and Status Registers

This block is the software-visible control bank of a small USB hub. It holds one register for the root port and one register per downstream port. The root register carries the hub-wide suspend control. Each downstream register carries the port's enable, speed, reset, resume and suspend controls. Every register also returns the D+/D− line state of its port.

While the hub is awake, the line-state bits show a snapshot taken at the last end-of-frame sample strobe. While the hub is suspended, they show the lines directly. The block also gates repeater traffic for each port, in both directions. It raises a flag once enough end-of-frame strobes have passed without a start-of-frame token, which tells software that it may suspend the hub.

Access is single-cycle: an address, a write strobe and write data that take effect on the next clock edge, and read data that follows the address combinationally. The analog transceiver, packet decoding and the repeater datapath are outside this block.

Top module: `usb_hub_port_regs`

## Requirements
- R1: After reset, every register reads 0x00, `suspend_ok` is 0, and all port enable, reset, suspend and traffic-pass outputs are 0.
- R2: A downstream register has this layout: bit 7 enable, bit 6 low-speed, bit 5 port reset, bit 4 resume, bit 3 port suspend, bit 2 always 0, bit 1 D+, bit 0 D−. Writes update bits 7..3 on the next edge, and written values for bits 2..0 are ignored. `port_line[2i+1]` is D+ and `port_line[2i]` is D− of port i.
- R3: While the global suspend bit is 0, the D+/D− read bits of the root port and of every downstream port return the line values captured on the last clock edge at which `eof_strobe` was 1. Later line changes are not visible until the next strobe.
- R4: While the global suspend bit is 1, the D+/D− read bits follow the live line inputs combinationally.
- R5: A port's enable bit becomes 1 only through a register write with bit 7 set. It is cleared by a write with bit 7 clear or by a one-cycle `port_fault` pulse for that port. When a fault and a write of 1 arrive in the same cycle, the enable ends up 0.
- R6: `suspend_ok` is 1 once three `eof_strobe` pulses have been counted since the last `sof_seen`. The count saturates, so further strobes keep it at 1. A `sof_seen` pulse, including one in the same cycle as a strobe, clears the count, and `suspend_ok` reads 0 after that edge.
- R7: While the global suspend bit is 1, a port passes no traffic in either direction unless its resume bit is 1. While it is 0, an enabled port passes traffic.
- R8: Upstream traffic passes on any enabled, unblocked port. Downstream traffic passes on such a port only if it is full-speed (low-speed bit 0), or if `preamble_seen` is 1.
- R9: The root register sits at `BASE_ADDR`, and downstream port i sits at `BASE_ADDR+1+i`. In the root register, bit 7 is the read/write global suspend bit, bits 6..2 read 0, bit 1 is root D+ and bit 0 is root D−.
- R10: Addresses outside the mapped range read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| eof_strobe | input | 1 | End-of-frame sample strobe, one cycle, about once per millisecond |
| sof_seen | input | 1 | One-cycle pulse when a start-of-frame token is detected |
| preamble_seen | input | 1 | Current downstream packet was preceded by a preamble PID |
| root_line | input | 2 | Root port lines, {D+, D−} |
| port_line | input | 2*NPORTS | Downstream lines, {D+, D−} per port |
| port_fault | input | NPORTS | Per-port fault pulse that clears the enable |
| port_en | output | NPORTS | Port enable state |
| port_rst | output | NPORTS | Port reset control |
| port_susp | output | NPORTS | Port suspend control |
| port_pass_up | output | NPORTS | Upstream traffic allowed |
| port_pass_down | output | NPORTS | Downstream traffic allowed |
| suspend_ok | output | 1 | Start-of-frame absence reached the suspend threshold |

## Verification
On every cycle, the assertions check that a fault clears the enable and that the enable only rises after a matching write. They check that a start-of-frame pulse drops `suspend_ok`, and that `suspend_ok` only rises on a strobe. They also check that suspend without resume blocks a port, and that downstream pass on a low-speed port needs a preamble. Only the bench scenarios can show the following: the exact read layout over all 256 write values, the choice between snapshot and live lines, the saturation of the miss counter after many strobes, and the silence of unmapped addresses.

// File: rtl/hub_regs_pkg.sv
`timescale 1ns/1ps
// Shared field positions and types for the hub register bank.
// Assumes 8-bit registers; the layout is fixed by the software view.
package hub_regs_pkg;
    localparam int REG_W  = 8;
    localparam int B_EN   = 7;
    localparam int B_LS   = 6;
    localparam int B_PRST = 5;
    localparam int B_RES  = 4;
    localparam int B_SUS  = 3;
    localparam int B_GSUS = 7;

    typedef struct packed {
        logic en;
        logic lowsp;
        logic prst;
        logic resume;
        logic susp;
    } port_ctl_t;

    // Assemble a downstream register read value.
    function automatic logic [REG_W-1:0] port_read(port_ctl_t c, logic [1:0] ln);
        return {c.en, c.lowsp, c.prst, c.resume, c.susp, 1'b0, ln};
    endfunction
endpackage

// File: rtl/hub_sof_watch.sv
`timescale 1ns/1ps
// Counts end-of-frame strobes since the last start-of-frame token.
// Saturates at MISS_LIMIT; a start-of-frame clears it and takes priority
// over a strobe in the same cycle.
module hub_sof_watch #(
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eof_strobe,
    input  logic sof_seen,
    output logic limit_hit
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MISS_LIMIT);

    logic [CW-1:0] miss_cnt;

    // Advance, clear or hold the missed-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_cnt <= '0;
        else if (sof_seen)
            miss_cnt <= '0;
        else if (eof_strobe && miss_cnt != LIMIT)
            miss_cnt <= miss_cnt + 1'b1;
    end

    assign limit_hit = (miss_cnt == LIMIT);
endmodule

// File: rtl/hub_line_hold.sv
`timescale 1ns/1ps
// Snapshot of a line-state bundle taken on each sample strobe, with a
// transparent bypass. Assumes the line inputs are already synchronised.
module hub_line_hold #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         transparent,
    input  logic [W-1:0] line,
    output logic [W-1:0] view
);
    logic [W-1:0] held;

    // Capture the lines at each sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (sample)
            held <= line;
    end

    assign view = transparent ? line : held;
endmodule

// File: rtl/hub_port_slice.sv
`timescale 1ns/1ps
// One downstream port: control bits, line readback and traffic gating.
// Enable is set only by a write; a fault clears it and wins over a write.
module hub_port_slice
    import hub_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [7:3]       wdata,
    input  logic             fault,
    input  logic             glob_susp,
    input  logic             preamble,
    input  logic             eof,
    input  logic [1:0]       line,
    output logic [REG_W-1:0] rdata,
    output port_ctl_t        ctl,
    output logic             pass_up,
    output logic             pass_down
);
    logic [1:0] line_view;
    logic       blocked;

    // Control bits: software write first, fault clear last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_sel) begin
                ctl.en     <= wdata[B_EN];
                ctl.lowsp  <= wdata[B_LS];
                ctl.prst   <= wdata[B_PRST];
                ctl.resume <= wdata[B_RES];
                ctl.susp   <= wdata[B_SUS];
            end
            if (fault)
                ctl.en <= 1'b0;
        end
    end

    hub_line_hold #(.W(2)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (eof),
        .transparent (glob_susp),
        .line        (line),
        .view        (line_view)
    );

    assign blocked   = glob_susp && !ctl.resume;
    assign pass_up   = ctl.en && !blocked;
    assign pass_down = pass_up && (!ctl.lowsp || preamble);
    assign rdata     = port_read(ctl, line_view);
endmodule

// File: rtl/usb_hub_port_regs.sv
`timescale 1ns/1ps
// Register bank for a small USB hub: one root register at BASE_ADDR and
// NPORTS downstream registers after it. Single-cycle access, combinational
// read. Line inputs are assumed to be synchronised to clk.
module usb_hub_port_regs
    import hub_regs_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int ADDR_W     = 3,
    parameter int BASE_ADDR  = 0,
    parameter int MISS_LIMIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                eof_strobe,
    input  logic                sof_seen,
    input  logic                preamble_seen,
    input  logic [1:0]          root_line,
    input  logic [2*NPORTS-1:0] port_line,
    input  logic [NPORTS-1:0]   port_fault,
    output logic [NPORTS-1:0]   port_en,
    output logic [NPORTS-1:0]   port_rst,
    output logic [NPORTS-1:0]   port_susp,
    output logic [NPORTS-1:0]   port_pass_up,
    output logic [NPORTS-1:0]   port_pass_down,
    output logic                suspend_ok
);
    localparam logic [ADDR_W-1:0] ROOT_A = ADDR_W'(BASE_ADDR);

    logic             glob_susp;
    logic [1:0]       root_view;
    logic             root_hit;
    logic [NPORTS-1:0] lowsp_v;
    logic [NPORTS-1:0] resume_v;
    logic [REG_W-1:0] slice_rd [NPORTS];
    logic [2:0]       unused_wdata;

    assign unused_wdata = reg_wdata[2:0];
    assign root_hit     = (reg_addr == ROOT_A);

    // Global suspend control bit in the root register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_susp <= 1'b0;
        else if (reg_wr && root_hit)
            glob_susp <= reg_wdata[B_GSUS];
    end

    hub_line_hold #(.W(2)) u_root_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (eof_strobe),
        .transparent (glob_susp),
        .line        (root_line),
        .view        (root_view)
    );

    hub_sof_watch #(.MISS_LIMIT(MISS_LIMIT)) u_sof (
        .clk        (clk),
        .rst_n      (rst_n),
        .eof_strobe (eof_strobe),
        .sof_seen   (sof_seen),
        .limit_hit  (suspend_ok)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(BASE_ADDR + 1 + i);
        port_ctl_t ctl;

        hub_port_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (reg_wr && (reg_addr == MY_A)),
            .wdata     (reg_wdata[7:3]),
            .fault     (port_fault[i]),
            .glob_susp (glob_susp),
            .preamble  (preamble_seen),
            .eof       (eof_strobe),
            .line      (port_line[2*i +: 2]),
            .rdata     (slice_rd[i]),
            .ctl       (ctl),
            .pass_up   (port_pass_up[i]),
            .pass_down (port_pass_down[i])
        );

        assign port_en[i]   = ctl.en;
        assign port_rst[i]  = ctl.prst;
        assign port_susp[i] = ctl.susp;
        assign lowsp_v[i]   = ctl.lowsp;
        assign resume_v[i]  = ctl.resume;
    end

    // Read mux: root, then each port; anything else reads zero.
    always_comb begin
        reg_rdata = '0;
        if (root_hit)
            reg_rdata = {glob_susp, 5'b0, root_view};
        for (int i = 0; i < NPORTS; i++) begin
            if (reg_addr == ADDR_W'(BASE_ADDR + 1 + i))
                reg_rdata = slice_rd[i];
        end
    end
endmodule

// File: rtl/hub_port_regs_check.sv
`timescale 1ns/1ps
// Protocol checks for usb_hub_port_regs, attached with bind.
module hub_port_regs_check #(
    parameter int NPORTS    = 4,
    parameter int ADDR_W    = 3,
    parameter int BASE_ADDR = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [7:0]          reg_wdata,
    input logic                eof_strobe,
    input logic                sof_seen,
    input logic                preamble_seen,
    input logic                glob_susp,
    input logic [NPORTS-1:0]   port_fault,
    input logic [NPORTS-1:0]   port_en,
    input logic [NPORTS-1:0]   lowsp_v,
    input logic [NPORTS-1:0]   resume_v,
    input logic [NPORTS-1:0]   port_pass_up,
    input logic [NPORTS-1:0]   port_pass_down,
    input logic                suspend_ok
);
    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        // R5: a fault leaves the enable cleared on the next cycle
        p_fault_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            port_fault[i] |=> !port_en[i]);

        // R5: the enable only rises after a write of 1 to its register
        p_enable_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_en[i]) |-> $past(reg_wr && reg_wdata[7] &&
                                        reg_addr == ADDR_W'(BASE_ADDR + 1 + i)));

        // R7: suspended port without resume passes nothing
        p_suspend_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (glob_susp && !resume_v[i]) |-> !(port_pass_up[i] || port_pass_down[i]));

        // R8: downstream on a low-speed port needs a preamble
        p_lowspeed_preamble_r8: assert property (@(posedge clk) disable iff (!rst_n)
            port_pass_down[i] |-> (port_en[i] && port_pass_up[i] &&
                                   (!lowsp_v[i] || preamble_seen)));
    end

    // R6: a start-of-frame drops the eligibility flag
    p_sof_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_seen |=> !suspend_ok);

    // R6: the flag only rises on a strobe without start-of-frame
    p_rise_on_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend_ok) |-> $past(eof_strobe && !sof_seen));
endmodule

bind usb_hub_port_regs hub_port_regs_check #(
    .NPORTS    (NPORTS),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_check (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .eof_strobe     (eof_strobe),
    .sof_seen       (sof_seen),
    .preamble_seen  (preamble_seen),
    .glob_susp      (glob_susp),
    .port_fault     (port_fault),
    .port_en        (port_en),
    .lowsp_v        (lowsp_v),
    .resume_v       (resume_v),
    .port_pass_up   (port_pass_up),
    .port_pass_down (port_pass_down),
    .suspend_ok     (suspend_ok)
);

// File: tb/usb_hub_port_regs_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every write value on every port and walks
// the line-view, fault, gating and start-of-frame scenarios.
module usb_hub_port_regs_test;
    localparam int NP = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          eof_strobe = 1'b0;
    logic          sof_seen = 1'b0;
    logic          preamble_seen = 1'b0;
    logic [1:0]    root_line = 2'b00;
    logic [2*NP-1:0] port_line = '0;
    logic [NP-1:0] port_fault = '0;
    logic [NP-1:0] port_en, port_rst, port_susp, port_pass_up, port_pass_down;
    logic          suspend_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_hub_port_regs #(.NPORTS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eof_strobe(eof_strobe),
        .sof_seen(sof_seen), .preamble_seen(preamble_seen), .root_line(root_line),
        .port_line(port_line), .port_fault(port_fault), .port_en(port_en),
        .port_rst(port_rst), .port_susp(port_susp), .port_pass_up(port_pass_up),
        .port_pass_down(port_pass_down), .suspend_ok(suspend_ok)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_eof();
        @(negedge clk); eof_strobe = 1'b1;
        @(negedge clk); eof_strobe = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof_seen = 1'b1;
        @(negedge clk); sof_seen = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [2*NP-1:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of all registers and outputs
        for (int a = 0; a <= NP; a++) begin
            rd(AW'(a), d);
            chk("R1 reg", d, 8'h00);
        end
        chk("R1 outs", {port_en, port_pass_up}, 8'h00);
        chk("R1 ctl", {port_rst, port_susp}, 8'h00);
        chk("R1 suspend_ok", {7'b0, suspend_ok}, 8'h00);

        // R2/R3: latch a line pattern, then sweep every write value
        port_line = 8'h36; root_line = 2'b10;
        pulse_eof();
        snap = port_line;
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr(AW'(p + 1), 8'(v));
                rd(AW'(p + 1), d);
                chk("R2 sweep", d, (8'(v) & 8'hF8) | {6'b0, snap[2*p +: 2]});
            end
            wr(AW'(p + 1), 8'h00);
        end

        // R3: line changes stay hidden until the next strobe
        port_line = ~snap; root_line = 2'b01;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            rd(AW'(p + 1), d);
            chk("R3 held", d, {6'b0, snap[2*p +: 2]});
        end
        rd(AW'(0), d);
        chk("R3 root held", d, 8'h02);
        pulse_eof();
        for (int p = 0; p < NP; p++) begin
            rd(AW'(p + 1), d);
            chk("R3 updated", d, {6'b0, ~snap[2*p +: 2]});
        end
        rd(AW'(0), d);
        chk("R3 root updated", d, 8'h01);

        // R9/R4: global suspend bit and live line view
        wr(AW'(0), 8'hFF);
        rd(AW'(0), d);
        chk("R9 root layout", d, 8'h81);
        root_line = 2'b11; port_line = 8'hA5;
        rd(AW'(0), d);
        chk("R4 root live", d, 8'h83);
        for (int p = 0; p < NP; p++) begin
            rd(AW'(p + 1), d);
            chk("R4 port live", d, {6'b0, port_line[2*p +: 2]});
        end

        // R7: suspended hub blocks enabled ports until resume
        for (int p = 0; p < NP; p++) wr(AW'(p + 1), 8'h80);
        #1;
        chk("R7 blocked up", {4'b0, port_pass_up}, 8'h00);
        chk("R7 blocked down", {4'b0, port_pass_down}, 8'h00);
        wr(AW'(1), 8'h90);
        #1;
        chk("R7 resume up", {4'b0, port_pass_up}, 8'h01);
        wr(AW'(0), 8'h00);
        #1;
        chk("R7 awake", {4'b0, port_pass_up}, 8'h0F);

        // R8: low-speed port needs preamble downstream only
        wr(AW'(2), 8'hC0);
        preamble_seen = 1'b0;
        #1;
        chk("R8 no preamble down", {4'b0, port_pass_down}, 8'h0D);
        chk("R8 no preamble up", {4'b0, port_pass_up}, 8'h0F);
        preamble_seen = 1'b1;
        #1;
        chk("R8 preamble down", {4'b0, port_pass_down}, 8'h0F);
        preamble_seen = 1'b0;

        // R5: fault clears the enable; fault beats a same-cycle write
        @(negedge clk); port_fault = 4'b0001;
        @(negedge clk); port_fault = 4'b0000;
        #1;
        chk("R5 fault clear", {4'b0, port_en}, 8'h0E);
        wr(AW'(3), 8'h00);
        @(negedge clk);
        reg_addr = AW'(3); reg_wr = 1'b1; reg_wdata = 8'h80; port_fault = 4'b0100;
        @(negedge clk);
        reg_wr = 1'b0; port_fault = 4'b0000;
        rd(AW'(3), d);
        chk("R5 fault wins", d & 8'h80, 8'h00);
        wr(AW'(3), 8'hA8);
        #1;
        chk("R5 write sets", {port_en[2], port_rst[2], port_susp[2], 5'b0}, 8'hE0);

        // R6: start-of-frame absence counting with saturation
        pulse_sof();
        pulse_eof(); pulse_eof();
        #1;
        chk("R6 two misses", {7'b0, suspend_ok}, 8'h00);
        pulse_eof();
        #1;
        chk("R6 three misses", {7'b0, suspend_ok}, 8'h01);
        for (int k = 0; k < 7; k++) pulse_eof();
        #1;
        chk("R6 saturated", {7'b0, suspend_ok}, 8'h01);
        pulse_sof();
        #1;
        chk("R6 sof clears", {7'b0, suspend_ok}, 8'h00);
        pulse_eof(); pulse_eof();
        @(negedge clk); eof_strobe = 1'b1; sof_seen = 1'b1;
        @(negedge clk); eof_strobe = 1'b0; sof_seen = 1'b0;
        #1;
        chk("R6 sof beats eof", {7'b0, suspend_ok}, 8'h00);

        // R10: unmapped addresses read 0 and ignore writes
        rd(AW'(1), d); snap[7:0] = d;
        for (int a = NP + 1; a < (1 << AW); a++) begin
            wr(AW'(a), 8'hFF);
            rd(AW'(a), d);
            chk("R10 unmapped", d, 8'h00);
        end
        rd(AW'(0), d);
        chk("R10 root untouched", d & 8'h80, 8'h00);
        rd(AW'(1), d);
        chk("R10 port untouched", d, snap[7:0]);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule